// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates six interrupt sources for a small processor core: two external request pins, two timer overflow flags, a serial-port request (either of two flags) and a second-timer request (either of two flags). A global enable and a per-source enable gate every request. A per-source priority bit places each source at the low or the high level. The block offers the winning request to the core as a service vector and tracks which levels are currently being serviced, so that a running handler can be pre-empted only by a request of a strictly higher level.

The external pins are sampled once per machine cycle on the `tick` strobe. Per pin, a mode bit selects whether the request follows a low level or is latched from a falling edge. Edge flags and timer flags belong to the block and are cleared by hardware when the core accepts their vector. Serial and second-timer flags are inputs owned by software and stay asserted until software drops them.

The offer to the core is a valid/ready stream. Once `irq_valid` is high, `irq_vector` and `irq_level` hold steady until the core raises `irq_ready`. The offer is taken on the clock edge where both are high. A held offer is never replaced, even by a request that would now win. After a take, the next offer can appear no earlier than the second edge that follows. `ret_pulse` marks the end of a handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `glb_en` is 0 no offer is raised; pending flags stay latched and are offered once `glb_en` returns to 1.
- R2: A source whose bit in `src_en` is 0 is never offered. Bit index order is ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, timer2=5.
- R3: The offered vector is 0003h + 8 × index: ext0 0003h, tmr0 000Bh, ext1 0013h, tmr1 001Bh, serial 0023h, timer2 002Bh.
- R4: Among eligible requests at the same level, the lowest index wins.
- R5: A source with its `src_hi` bit set is high level (`irq_level`=1) and wins over any low-level request.
- R6: While the high level is active (`act_lvl[1]`=1) nothing is offered. While only the low level is active, only high-level requests are offered.
- R7: `ret_pulse` clears `act_lvl[1]` if it is set, otherwise `act_lvl[0]`. A take sets `act_lvl[irq_level]`. On the same edge the clear is applied before the set.
- R8: With `ext_edge[i]`=0, external input i requests while its last tick sample is 0. No flag is kept, so the request stops once a 1 is sampled.
- R9: With `ext_edge[i]`=1, a tick sample of 0 that follows a tick sample of 1 sets the edge flag. The flag persists after the pin returns high.
- R10: Taking an ext or tmr vector clears that edge or timer flag. Taking a serial or timer2 vector clears nothing, so that request remains.
- R11: `irq_valid` stays high with `irq_vector` and `irq_level` stable until `irq_ready` is 1, and the take is on that edge.
- R12: After reset there is no offer, `act_lvl` is 0 and both pin samples read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe; external pins are sampled when high |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per-pin trigger mode: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow pulses that set the timer flags |
| ser_flag | input | 2 | Serial receive/transmit flags, ORed into one request |
| t2_flag | input | 2 | Timer 2 overflow/external flags, ORed into one request |
| glb_en | input | 1 | Global enable |
| src_en | input | 6 | Per-source enable |
| src_hi | input | 6 | Per-source priority, 1 = high level |
| ret_pulse | input | 1 | End of current handler |
| irq_valid | output | 1 | Offer present |
| irq_ready | input | 1 | Core accepts the offer |
| irq_vector | output | 16 | Service vector address of the offer |
| irq_level | output | 1 | Level of the offer |
| act_lvl | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
The hardest state to reach from the ports is both levels active, with requests still standing at each level, followed by two returns that must unwind in the right order. If sources are released freely, the arbiter settles on whatever wins first. The stimulus therefore stages each mix of flags while `glb_en` is low, so that every source is present when arbitration opens. It then accepts a low-level serial offer, raises a high-level timer 2 request on top, and issues returns one at a time, checking what is offered after each. Edge capture is provoked by holding a pin low across a tick with the global enable off, so that the offer can only come from the stored flag.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_LVL = 2;

  // source slots; the order is the polling order
  localparam logic [IDX_W-1:0] IX_EXT0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_TMR0 = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_EXT1 = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_TMR1 = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_SER  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_T2   = IDX_W'(5);
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic smp_q;
    logic eflag_q;
    logic fall;

    // one sample high, the next sample low
    assign fall = tick & smp_q & ~pin_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b1;
      end else if (tick) begin
        smp_q <= pin_n[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eflag_q <= 1'b0;
      end else if (!edge_sel[g]) begin
        eflag_q <= 1'b0;
      end else if (fall) begin
        eflag_q <= 1'b1;
      end else if (clr[g]) begin
        eflag_q <= 1'b0;
      end
    end

    assign req[g] = edge_sel[g] ? eflag_q : ~smp_q;
  end
endmodule

// File: rtl/irq_tmr_flags.sv
module irq_tmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
      end else if (set[g]) begin
        f_q <= 1'b1;
      end else if (clr[g]) begin
        f_q <= 1'b0;
      end
    end
    assign flag[g] = f_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     hi,
  input  logic [1:0]       busy,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             lvl
);
  logic [N-1:0]     elig_hi;
  logic [N-1:0]     elig_lo;
  logic             hi_open;
  logic             lo_open;
  logic             hi_hit;
  logic             lo_hit;
  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;

  assign hi_open = ~busy[1];
  assign lo_open = ~busy[1] & ~busy[0];
  assign elig_hi = req & hi & {N{hi_open}};
  assign elig_lo = req & ~hi & {N{lo_open}};

  // scan downward so the lowest slot is written last and wins
  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_hi[i]) begin
        hi_hit = 1'b1;
        hi_idx = IDX_W'(i);
      end
      if (elig_lo[i]) begin
        lo_hit = 1'b1;
        lo_idx = IDX_W'(i);
      end
    end
  end

  assign found = hi_hit | lo_hit;
  assign idx   = hi_hit ? hi_idx : lo_idx;
  assign lvl   = hi_hit;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int NUM_LVL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               take_lvl,
  input  logic               ret_pulse,
  output logic [NUM_LVL-1:0] busy
);
  logic [NUM_LVL-1:0] busy_q;
  logic [NUM_LVL-1:0] busy_d;

  always_comb begin
    busy_d = busy_q;
    if (ret_pulse) begin
      // unwind the topmost active level
      if (busy_q[1]) busy_d[1] = 1'b0;
      else           busy_d[0] = 1'b0;
    end
    if (take) busy_d[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_EXT-1:0]   ext_n,
  input  logic [NUM_EXT-1:0]   ext_edge,
  input  logic [NUM_TMR-1:0]   tmr_ovf,
  input  logic [1:0]           ser_flag,
  input  logic [1:0]           t2_flag,
  input  logic                 glb_en,
  input  logic [NUM_SRC-1:0]   src_en,
  input  logic [NUM_SRC-1:0]   src_hi,
  input  logic                 ret_pulse,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [VEC_W-1:0]     irq_vector,
  output logic                 irq_level,
  output logic [NUM_LVL-1:0]   act_lvl
);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);

  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_EXT-1:0] ext_clr;
  logic [NUM_TMR-1:0] tmr_flag;
  logic [NUM_TMR-1:0] tmr_clr;
  logic [NUM_SRC-1:0] raw_req;
  logic [NUM_SRC-1:0] gated_req;
  logic [NUM_LVL-1:0] busy;
  logic               win_found;
  logic [IDX_W-1:0]   win_idx;
  logic               win_lvl;
  logic               offer_q;
  logic [IDX_W-1:0]   offer_idx_q;
  logic               offer_lvl_q;
  logic               take;

  assign take = offer_q & irq_ready;

  // hardware clears for the flags this block owns
  assign ext_clr = {take & (offer_idx_q == IX_EXT1), take & (offer_idx_q == IX_EXT0)};
  assign tmr_clr = {take & (offer_idx_q == IX_TMR1), take & (offer_idx_q == IX_TMR0)};

  irq_ext_sense #(.N(NUM_EXT)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pin_n    (ext_n),
    .edge_sel (ext_edge),
    .clr      (ext_clr),
    .req      (ext_req)
  );

  irq_tmr_flags #(.N(NUM_TMR)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tmr_ovf),
    .clr   (tmr_clr),
    .flag  (tmr_flag)
  );

  always_comb begin
    raw_req          = '0;
    raw_req[IX_EXT0] = ext_req[0];
    raw_req[IX_TMR0] = tmr_flag[0];
    raw_req[IX_EXT1] = ext_req[1];
    raw_req[IX_TMR1] = tmr_flag[1];
    raw_req[IX_SER]  = |ser_flag;
    raw_req[IX_T2]   = |t2_flag;
  end

  assign gated_req = raw_req & src_en & {NUM_SRC{glb_en}};

  irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req   (gated_req),
    .hi    (src_hi),
    .busy  (busy),
    .found (win_found),
    .idx   (win_idx),
    .lvl   (win_lvl)
  );

  irq_level_track #(.NUM_LVL(NUM_LVL)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_lvl  (offer_lvl_q),
    .ret_pulse (ret_pulse),
    .busy      (busy)
  );

  // offer register: loaded only when empty, held until taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_q     <= 1'b0;
      offer_idx_q <= '0;
      offer_lvl_q <= 1'b0;
    end else if (offer_q) begin
      if (irq_ready) offer_q <= 1'b0;
    end else if (win_found) begin
      offer_q     <= 1'b1;
      offer_idx_q <= win_idx;
      offer_lvl_q <= win_lvl;
    end
  end

  assign irq_valid  = offer_q;
  assign irq_level  = offer_lvl_q;
  assign irq_vector = BASE_V + STEP_V * VEC_W'(offer_idx_q);
  assign act_lvl    = busy;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             ret_pulse,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_level,
  input logic [1:0]       act_lvl
);
  // R11
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector) && $stable(irq_level));

  // R1
  offer_needs_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(glb_en));

  // R3
  vector_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (((irq_vector - VEC_W'(3)) & VEC_W'(7)) == '0)
                  && irq_vector >= VEC_W'(3) && irq_vector <= VEC_W'(43));

  // R6
  nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !act_lvl[1] && (irq_level || !act_lvl[0]));

  // R7
  ret_top_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && act_lvl[1] && !(irq_valid && irq_ready)
      |=> !act_lvl[1] && (act_lvl[0] == $past(act_lvl[0])));

  // R7
  ret_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && !act_lvl[1] && !(irq_valid && irq_ready) |=> act_lvl == 2'b00);

  // R11
  take_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && !ret_pulse
      |=> ($past(irq_level) ? act_lvl[1] : act_lvl[0]));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.VEC_W(VEC_W)) u_nest_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .ret_pulse  (ret_pulse),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .irq_level  (irq_level),
  .act_lvl    (act_lvl)
);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  ext_edge = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic [1:0]  ser_flag = 2'b00;
  logic [1:0]  t2_flag = 2'b00;
  logic        glb_en = 1'b0;
  logic [5:0]  src_en = 6'h00;
  logic [5:0]  src_hi = 6'h00;
  logic        ret_pulse = 1'b0;
  logic        irq_ready = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic        irq_level;
  logic [1:0]  act_lvl;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .t2_flag(t2_flag), .glb_en(glb_en),
    .src_en(src_en), .src_hi(src_hi), .ret_pulse(ret_pulse), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_level(irq_level), .act_lvl(act_lvl)
  );

  // machine-cycle strobe: one cycle in four
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= ((cyc % 4) == 0);
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_smp[2];
  bit m_ef[2];
  bit m_tf[2];
  bit m_ins[2];
  bit m_pv;
  int m_src;
  bit m_lvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_smp = '{1'b1, 1'b1};
      m_ef  = '{1'b0, 1'b0};
      m_tf  = '{1'b0, 1'b0};
      m_ins = '{1'b0, 1'b0};
      m_pv  = 1'b0;
      m_src = 0;
      m_lvl = 1'b0;
    end else begin
      bit want[6];
      bit took;
      int win;
      bit win_lvl;
      want[0] = ext_edge[0] ? m_ef[0] : !m_smp[0];
      want[1] = m_tf[0];
      want[2] = ext_edge[1] ? m_ef[1] : !m_smp[1];
      want[3] = m_tf[1];
      want[4] = |ser_flag;
      want[5] = |t2_flag;
      win = -1;
      win_lvl = 1'b0;
      for (int pass = 1; pass >= 0; pass--) begin
        for (int s = 0; s < 6; s++) begin
          bit open;
          open = (pass == 1) ? !m_ins[1] : (!m_ins[1] && !m_ins[0]);
          if (win < 0 && want[s] && glb_en && src_en[s] && (src_hi[s] == pass[0]) && open) begin
            win = s;
            win_lvl = pass[0];
          end
        end
      end
      took = m_pv && irq_ready;
      for (int e = 0; e < 2; e++) begin
        if (!ext_edge[e]) m_ef[e] = 1'b0;
        else if (tick && m_smp[e] && !ext_n[e]) m_ef[e] = 1'b1;
        else if (took && m_src == 2 * e) m_ef[e] = 1'b0;
        if (tick) m_smp[e] = ext_n[e];
      end
      for (int t = 0; t < 2; t++) begin
        if (tmr_ovf[t]) m_tf[t] = 1'b1;
        else if (took && m_src == 2 * t + 1) m_tf[t] = 1'b0;
      end
      if (ret_pulse) begin
        if (m_ins[1]) m_ins[1] = 1'b0;
        else m_ins[0] = 1'b0;
      end
      if (took) m_ins[m_lvl] = 1'b1;
      if (m_pv) begin
        if (took) m_pv = 1'b0;
      end else if (win >= 0) begin
        m_pv = 1'b1;
        m_src = win;
        m_lvl = win_lvl;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 model valid", int'(irq_valid), int'(m_pv));
      if (m_pv) begin
        chk("R3 model vector", int'(irq_vector), 3 + 8 * m_src);
        chk("R5 model level", int'(irq_level), int'(m_lvl));
      end
      chk("R7 model act_lvl", int'(act_lvl), {30'd0, m_ins[1], m_ins[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic expect_offer(string tag, int vec, int lvl);
    int k = 0;
    @(negedge clk);
    while (!irq_valid && k < 24) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " valid"}, int'(irq_valid), 1);
    chk({tag, " vector"}, int'(irq_vector), vec);
    chk({tag, " level"}, int'(irq_level), lvl);
  endtask

  task automatic expect_none(string tag, int n);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq_valid) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  task automatic take_offer();
    @(negedge clk); #1 irq_ready = 1'b1;
    @(negedge clk); #1 irq_ready = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); #1 ret_pulse = 1'b1;
    @(negedge clk); #1 ret_pulse = 1'b0;
  endtask

  task automatic pulse_tmr(int t);
    @(negedge clk); #1 tmr_ovf[t] = 1'b1;
    @(negedge clk); #1 tmr_ovf[t] = 1'b0;
  endtask

  task automatic set_glb(bit v);
    @(negedge clk); #1 glb_en = v;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset valid", int'(irq_valid), 0);
    chk("R12 reset act_lvl", int'(act_lvl), 0);
    expect_none("R12 pins idle high give no request", 6);

    // R1 global gate, timer 0 flag held and auto-cleared
    @(negedge clk); #1 src_en = 6'h3F;
    pulse_tmr(0);
    expect_none("R1 glb_en=0 blocks", 8);
    set_glb(1'b1);
    expect_offer("R1 R3 tmr0", 16'h000B, 0);
    take_offer();
    chk("R11 take sets low level", int'(act_lvl), 2'b01);
    do_ret();
    chk("R7 ret clears low", int'(act_lvl), 0);
    expect_none("R10 tmr0 flag cleared on take", 8);

    // R2 per-source enable, serial flag not auto-cleared
    @(negedge clk); #1 src_en = 6'b101111; ser_flag = 2'b01;
    expect_none("R2 disabled serial", 8);
    @(negedge clk); #1 src_en = 6'h3F;
    expect_offer("R2 R3 serial", 16'h0023, 0);
    take_offer();
    expect_none("R6 low busy blocks low", 6);
    do_ret();
    expect_offer("R10 serial kept after take", 16'h0023, 0);
    take_offer();
    @(negedge clk); #1 ser_flag = 2'b00;
    do_ret();
    expect_none("R10 serial dropped by software", 6);

    // R4 polling order, R11 hold under back-pressure
    set_glb(1'b0);
    @(negedge clk); #1 ser_flag = 2'b10; t2_flag = 2'b01;
    pulse_tmr(1);
    set_glb(1'b1);
    expect_offer("R4 tmr1 first", 16'h001B, 0);
    repeat (5) @(negedge clk);
    chk("R11 held valid", int'(irq_valid), 1);
    chk("R11 held vector", int'(irq_vector), 16'h001B);
    take_offer();
    do_ret();
    expect_offer("R4 serial before timer2", 16'h0023, 0);
    take_offer();
    @(negedge clk); #1 ser_flag = 2'b00;
    do_ret();
    expect_offer("R4 R3 timer2", 16'h002B, 0);
    take_offer();
    @(negedge clk); #1 t2_flag = 2'b00;
    do_ret();
    expect_none("R4 all drained", 6);

    // R5 high level wins, R6 nesting, R7 unwind
    set_glb(1'b0);
    @(negedge clk); #1 src_hi = 6'b100000; ser_flag = 2'b01; t2_flag = 2'b10;
    set_glb(1'b1);
    expect_offer("R5 high timer2 wins", 16'h002B, 1);
    take_offer();
    chk("R5 high level active", int'(act_lvl), 2'b10);
    expect_none("R6 high busy blocks low", 6);
    @(negedge clk); #1 t2_flag = 2'b00;
    do_ret();
    chk("R7 ret clears high", int'(act_lvl), 0);
    expect_offer("R6 low after high", 16'h0023, 0);
    take_offer();
    @(negedge clk); #1 t2_flag = 2'b01;
    expect_offer("R6 high pre-empts low", 16'h002B, 1);
    take_offer();
    chk("R6 both levels active", int'(act_lvl), 2'b11);
    expect_none("R6 nothing while both active", 6);
    @(negedge clk); #1 t2_flag = 2'b00;
    do_ret();
    chk("R7 first ret clears high only", int'(act_lvl), 2'b01);
    expect_none("R6 low still busy", 6);
    do_ret();
    chk("R7 second ret clears low", int'(act_lvl), 0);
    expect_offer("R7 serial resumes", 16'h0023, 0);
    take_offer();
    @(negedge clk); #1 ser_flag = 2'b00;
    do_ret();

    // R6 same high level cannot interrupt high
    set_glb(1'b0);
    @(negedge clk); #1 src_hi = 6'b110000; ser_flag = 2'b10; t2_flag = 2'b01;
    set_glb(1'b1);
    expect_offer("R4 high serial first", 16'h0023, 1);
    take_offer();
    expect_none("R6 same high level blocked", 6);
    @(negedge clk); #1 ser_flag = 2'b00;
    do_ret();
    expect_offer("R6 timer2 after ret", 16'h002B, 1);
    take_offer();
    @(negedge clk); #1 t2_flag = 2'b00; src_hi = 6'h00;
    do_ret();
    expect_none("R6 drained", 6);

    // R9 falling-edge capture on ext1
    set_glb(1'b0);
    @(negedge clk); #1 ext_edge[1] = 1'b1; ext_n[1] = 1'b0;
    repeat (6) @(negedge clk);
    #1 ext_n[1] = 1'b1;
    repeat (8) @(negedge clk);
    set_glb(1'b1);
    expect_offer("R9 R3 ext1 edge latched", 16'h0013, 0);
    take_offer();
    do_ret();
    expect_none("R10 R9 edge flag cleared on take", 10);

    // R8 level mode on ext0
    @(negedge clk); #1 ext_edge[0] = 1'b0; ext_n[0] = 1'b0;
    expect_offer("R8 R3 ext0 low level", 16'h0003, 0);
    take_offer();
    do_ret();
    expect_offer("R8 still low re-requests", 16'h0003, 0);
    take_offer();
    @(negedge clk); #1 ext_n[0] = 1'b1;
    repeat (6) @(negedge clk);
    do_ret();
    expect_none("R8 high pin stops request", 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w = 0;
    while (!done && w < 100000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected=finish", w);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule